// File: doc/BRIEF.md
# Three-wire serial EEPROM device logic

This block is the device end of a three-wire serial EEPROM. A host asserts a select line, clocks command bits in on a serial data input and reads results back on a serial data output. The output comes as a data value plus a separate output-enable, so the pad can be tri-stated outside the block. A run-time input picks the word size: bytes, or 16-bit words. The storage is a register array of bytes. Each 16-bit word uses two neighbouring bytes.

All pins are sampled in the system clock domain. A frame begins when the select line rises. Leading zeros are skipped until a start bit of 1 arrives. Then come a 2-bit opcode and the address field. Reads stream data out, continuing from word to word for as long as select stays high. The programming commands (write, erase, erase-all, write-all) only act once a protection latch has been opened. Each one starts a programming cycle of fixed length, counted in system clocks. If the host drops select and raises it again while that cycle runs, the output reports busy or ready.

Top module: `serial_eeprom_dev`

## Requirements
- R1: A frame starts at a rising select. Zeros on the data input before the first 1 are skipped. After that 1, the next two bits are the opcode (10 read, 01 write, 11 erase, 00 extended), sent MSB first. The address follows, MSB first: 9 bits in byte mode and 8 bits in word mode.
- R2: For a read, the output is enabled and drives a single 0 right after the last address bit. Each later serial clock rise then presents the next bit of the addressed word, MSB first.
- R3: While select stays high, a read continues into the next address with no extra 0 between words. The address wraps from the last location to location 0.
- R4: After reset the protection latch is closed. In that state, write, erase, erase-all and write-all leave the storage unchanged and start no programming cycle.
- R5: In an extended command, the two top address bits choose the action: 11 opens the latch, 00 closes it, 10 is erase-all, 01 is write-all. The latch stays in its state until the opposite command arrives.
- R6: A write takes 8 data bits in byte mode or 16 in word mode, MSB first. In word mode, word a occupies byte 2a (upper half) and byte 2a+1 (lower half).
- R7: Erase sets every bit of the addressed location to 1.
- R8: Erase-all sets every byte of the storage to 8'hFF.
- R9: Write-all stores its data word in every location of the current word size.
- R10: If select is raised while a programming cycle runs, the output is enabled and shows 0. It switches to 1 when the cycle ends and holds there until select falls.
- R11: If select is raised only after the programming cycle has ended, the output enable stays low.
- R12: The output enable is low after reset, and low whenever the synchronized select is low.
- R13: A frame that begins while a programming cycle runs is not executed.
- R14: If select falls before a frame is complete, the frame is dropped and the storage is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Chip select from the host, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdata_i | input | 1 | Serial command and data input |
| word16_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| sout_o | output | 1 | Serial output value |
| sout_en_o | output | 1 | Output enable for the serial output pad |

## Verification
Every pin passes two synchronizer flops and one edge-detect compare. A result therefore appears in the registered outputs on the third system clock edge after the pin changes. The bench holds each serial clock phase for six system clocks and samples five clocks after each rise. For a read, the dummy 0 is sampled at the rise of the last address bit, and one data bit is sampled at each rise after it. Busy status is sampled right after select is raised again. The ready value is sampled after the programming count plus a margin, and the high-impedance case is sampled after that same wait.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM device logic.
// Assumes: opcode and sub-command codes are fixed by the serial protocol.
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // select low
        ST_WAIT,   // select high, waiting for the start bit
        ST_HDR,    // shifting opcode and address
        ST_DATA,   // shifting write data
        ST_READ,   // streaming read data
        ST_STAT,   // showing ready/busy
        ST_HOLD    // frame done, ignore pins until select falls
    } eep_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } eep_op_e;

    localparam logic [1:0] SUB_LOCK   = 2'b00;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_WIPE   = 2'b10;
    localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/eep_pin_sync.sv
// Brings one asynchronous pin into the system clock domain.
// Gives the synchronized level plus one-cycle rise and fall pulses.
// Assumes: the pin stays stable for at least STAGES+1 system clocks.
module eep_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES:0] chain_q;

    // Synchronizer chain; the top bit keeps the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/eep_prog_timer.sv
// Self-timed programming cycle: once started, busy stays high for CYCLES clocks.
// Assumes: no new start arrives while busy (the controller ensures this).
module eep_prog_timer #(
    parameter int CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load the count on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R10: a start always leads to a busy phase.
    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R10: busy ends only when the count has run out.
    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cnt_q) == CW'(1)));

endmodule

// File: rtl/eep_store.sv
// Byte-organized register array with a read port and a write port for byte or 16-bit words.
// In word mode, word a is bytes 2a (upper) and 2a+1 (lower). Reset fills it with 8'hFF.
// Assumes: wr_one_i and wr_all_i are never high together.
module eep_store #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [15:0]   rd_data_o,
    input  logic          wr_one_i,
    input  logic          wr_all_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [15:0]   wr_data_i
);

    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] rd_hi, rd_lo, wr_hi, wr_lo;

    assign rd_hi = {rd_addr_i[AW-2:0], 1'b0};
    assign rd_lo = {rd_addr_i[AW-2:0], 1'b1};
    assign wr_hi = {wr_addr_i[AW-2:0], 1'b0};
    assign wr_lo = {wr_addr_i[AW-2:0], 1'b1};

    // Read mux: a pair of bytes in word mode, one byte in byte mode.
    always_comb begin
        if (wide_i) rd_data_o = {mem_q[rd_hi], mem_q[rd_lo]};
        else        rd_data_o = {8'h00, mem_q[rd_addr_i]};
    end

    // Storage update: reset to erased, fill everything, or one location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (wr_all_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wide_i && (i % 2 == 0)) mem_q[i] <= wr_data_i[15:8];
                else                        mem_q[i] <= wr_data_i[7:0];
            end
        end else if (wr_one_i) begin
            if (wide_i) begin
                mem_q[wr_hi] <= wr_data_i[15:8];
                mem_q[wr_lo] <= wr_data_i[7:0];
            end else begin
                mem_q[wr_addr_i] <= wr_data_i[7:0];
            end
        end
    end

endmodule

// File: rtl/eep_cmd_ctrl.sv
// Frame decoder and output sequencer. It shifts in the start bit, opcode, address and data,
// holds the programming latch, streams read data and shows ready/busy status.
// Assumes: synchronized inputs; word16_i is constant during a frame.
module eep_cmd_ctrl
    import eep_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl_i,
    input  logic          cs_rise_i,
    input  logic          cs_fall_i,
    input  logic          sk_rise_i,
    input  logic          din_i,
    input  logic          wide_i,
    input  logic          busy_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [15:0]   rd_data_i,
    output logic          wr_one_o,
    output logic          wr_all_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [15:0]   wr_data_o,
    output logic          prog_start_o,
    output logic          dout_o,
    output logic          dout_oe_o
);

    localparam int HW = AW + 2;
    localparam int CW = $clog2(AW + 18);

    eep_state_e    st_q;
    logic [HW-1:0] hdr_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] ptr_q, addr_q;
    logic [15:0]   out_q, dat_q;
    logic [CW-1:0] ocnt_q;
    logic          unlock_q, fill_q, dout_q, oe_q;

    logic [HW-1:0] hdr_next;
    logic [15:0]   dat_next, rd_aligned;
    eep_op_e       hdr_op;
    logic [1:0]    hdr_sub;
    logic [AW-1:0] hdr_addr, ptr_plus;
    logic [CW-1:0] hdr_lim, dat_lim, dw_len;
    logic          hdr_last, dat_last, erase_go, wipe_go;

    // Header and data shift values including the bit on the current serial clock rise.
    always_comb begin
        hdr_next = {hdr_q[HW-2:0], din_i};
        dat_next = {dat_q[14:0], din_i};
        hdr_lim  = wide_i ? CW'(AW) : CW'(AW + 1);
        dat_lim  = wide_i ? CW'(15) : CW'(7);
        dw_len   = wide_i ? CW'(16) : CW'(8);
    end

    // Split the header into opcode, sub-command and address for the current word size.
    always_comb begin
        if (wide_i) begin
            hdr_op   = eep_op_e'(hdr_next[AW:AW-1]);
            hdr_sub  = hdr_next[AW-2:AW-3];
            hdr_addr = {1'b0, hdr_next[AW-2:0]};
        end else begin
            hdr_op   = eep_op_e'(hdr_next[AW+1:AW]);
            hdr_sub  = hdr_next[AW-1:AW-2];
            hdr_addr = hdr_next[AW-1:0];
        end
    end

    // Next sequential address, wrapping at the top of the current word space.
    always_comb begin
        ptr_plus = ptr_q + 1'b1;
        if (wide_i) ptr_plus[AW-1] = 1'b0;
    end

    // Read port address and MSB-aligned read word.
    always_comb begin
        rd_addr_o  = (st_q == ST_READ) ? ptr_plus : hdr_addr;
        rd_aligned = wide_i ? rd_data_i : {rd_data_i[7:0], 8'h00};
    end

    // Last-bit detection and commit strobes for the programming commands.
    always_comb begin
        hdr_last = (st_q == ST_HDR) && sk_rise_i && (cnt_q == hdr_lim);
        dat_last = (st_q == ST_DATA) && sk_rise_i && (cnt_q == dat_lim);
        erase_go = hdr_last && (hdr_op == OP_ERASE) && unlock_q;
        wipe_go  = hdr_last && (hdr_op == OP_EXT) && (hdr_sub == SUB_WIPE) && unlock_q;
        wr_one_o = erase_go || (dat_last && !fill_q);
        wr_all_o = wipe_go || (dat_last && fill_q);
        wr_addr_o = erase_go ? hdr_addr : addr_q;
        if (erase_go || wipe_go) wr_data_o = 16'hFFFF;
        else if (wide_i)         wr_data_o = dat_next;
        else                     wr_data_o = {8'h00, dat_next[7:0]};
        prog_start_o = wr_one_o || wr_all_o;
    end

    // Frame state machine, programming latch and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            hdr_q    <= '0;
            cnt_q    <= '0;
            ptr_q    <= '0;
            addr_q   <= '0;
            out_q    <= '0;
            dat_q    <= '0;
            ocnt_q   <= '0;
            unlock_q <= 1'b0;
            fill_q   <= 1'b0;
            dout_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else if (cs_fall_i) begin
            st_q   <= ST_IDLE;
            dout_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cs_rise_i) begin
                        if (busy_i) begin
                            st_q   <= ST_STAT;
                            dout_q <= 1'b0;
                            oe_q   <= 1'b1;
                        end else begin
                            st_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sk_rise_i && din_i) begin
                        st_q  <= ST_HDR;
                        cnt_q <= '0;
                    end
                end
                ST_HDR: begin
                    if (sk_rise_i) begin
                        hdr_q <= hdr_next;
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (hdr_last) begin
                        st_q <= ST_HOLD;
                        unique case (hdr_op)
                            OP_READ: begin
                                st_q   <= ST_READ;
                                out_q  <= rd_aligned;
                                ocnt_q <= dw_len;
                                ptr_q  <= hdr_addr;
                                dout_q <= 1'b0;
                                oe_q   <= 1'b1;
                            end
                            OP_WRITE: begin
                                if (unlock_q) begin
                                    st_q   <= ST_DATA;
                                    cnt_q  <= '0;
                                    fill_q <= 1'b0;
                                    addr_q <= hdr_addr;
                                end
                            end
                            OP_ERASE: ;
                            OP_EXT: begin
                                if (hdr_sub == SUB_UNLOCK) unlock_q <= 1'b1;
                                if (hdr_sub == SUB_LOCK)   unlock_q <= 1'b0;
                                if (hdr_sub == SUB_FILL && unlock_q) begin
                                    st_q   <= ST_DATA;
                                    cnt_q  <= '0;
                                    fill_q <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    if (sk_rise_i) begin
                        dat_q <= dat_next;
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (dat_last) st_q <= ST_HOLD;
                end
                ST_READ: begin
                    if (sk_rise_i) begin
                        dout_q <= out_q[15];
                        if (ocnt_q == CW'(1)) begin
                            out_q  <= rd_aligned;
                            ocnt_q <= dw_len;
                            ptr_q  <= ptr_plus;
                        end else begin
                            out_q  <= {out_q[14:0], 1'b0};
                            ocnt_q <= ocnt_q - 1'b1;
                        end
                    end
                end
                ST_STAT: begin
                    dout_q <= ~busy_i;
                    oe_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign dout_o    = dout_q;
    assign dout_oe_o = oe_q;

    // R12: with select low, the output enable is low on the next cycle.
    assert_oe_follows_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl_i |=> !dout_oe_o);

    // R2: entering the read stream drives the enabled dummy zero.
    assert_dummy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ && $past(st_q) == ST_HDR) |-> (!dout_o && dout_oe_o));

    // R4: a programming cycle only begins with the latch open.
    assert_locked_no_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> $past(unlock_q));

    // R13: no new programming request while a cycle runs.
    assert_busy_blocks_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !prog_start_o);

    // R10: status is shown only when select came up during a busy phase.
    assert_status_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STAT && $past(st_q) == ST_IDLE) |-> $past(busy_i));

endmodule

// File: rtl/serial_eeprom_dev.sv
// Top level of the three-wire serial EEPROM device logic.
// Synchronizes the pins, then connects the frame controller, storage and programming timer.
// Assumes: the host keeps each serial clock phase longer than SYNC_STAGES+1 system clocks.
module serial_eeprom_dev #(
    parameter int ADDR_W      = 9,
    parameter int PROG_CYCLES = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdata_i,
    input  logic word16_i,
    output logic sout_o,
    output logic sout_en_o
);

    localparam int NPIN = 3;

    logic [NPIN-1:0]   pin_raw, pin_lvl, pin_rise, pin_fall;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [15:0]       rd_data, wr_data;
    logic              wr_one, wr_all, prog_start, busy;

    assign pin_raw = {sdata_i, sclk_i, sel_i};

    // One synchronizer per host pin.
    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_raw[g]),
            .lvl_o  (pin_lvl[g]),
            .rise_o (pin_rise[g]),
            .fall_o (pin_fall[g])
        );
    end

    eep_cmd_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_lvl_i     (pin_lvl[0]),
        .cs_rise_i    (pin_rise[0]),
        .cs_fall_i    (pin_fall[0]),
        .sk_rise_i    (pin_rise[1]),
        .din_i        (pin_lvl[2]),
        .wide_i       (word16_i),
        .busy_i       (busy),
        .rd_addr_o    (rd_addr),
        .rd_data_i    (rd_data),
        .wr_one_o     (wr_one),
        .wr_all_o     (wr_all),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .prog_start_o (prog_start),
        .dout_o       (sout_o),
        .dout_oe_o    (sout_en_o)
    );

    eep_store #(.AW(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_i    (word16_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_one_i  (wr_one),
        .wr_all_i  (wr_all),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );

    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy)
    );

    // R14: all three pin edges are unused in a pin-level sense except those wired above;
    // a select fall always clears the enable on the following cycle.
    assert_sel_fall_clears_R14: assert property (@(posedge clk) disable iff (!rst_n)
        pin_fall[0] |=> !sout_en_o);

endmodule

// File: tb/serial_eeprom_dev_bench.sv
// Self-checking bench: directed corner cases plus seeded random write/read traffic,
// checked against a byte model kept in the bench.
module serial_eeprom_dev_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 9;
    localparam int PROG       = 300;
    localparam int DEPTH      = 1 << AW;
    localparam int WDOG       = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdata = 1'b0, w16 = 1'b0;
    logic sout, sout_en;

    int total = 0;
    int bad = 0;
    logic smp_do, smp_oe;
    logic [7:0] model [DEPTH];
    logic unlocked = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_eeprom_dev #(.ADDR_W(AW), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_serial_eeprom_dev (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .sclk_i    (sclk),
        .sdata_i   (sdata),
        .word16_i  (w16),
        .sout_o    (sout),
        .sout_en_o (sout_en)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_bit(input logic b);
        sdata = b;
        idle(6);
        sclk = 1'b1;
        idle(5);
        smp_do = sout;
        smp_oe = sout_en;
        idle(1);
        sclk = 1'b0;
    endtask

    task automatic sel_on();
        sel = 1'b1;
        idle(6);
    endtask

    task automatic sel_off();
        sclk = 1'b0;
        sel = 1'b0;
        idle(6);
    endtask

    function automatic int aw_of(input logic wide);
        return wide ? AW - 1 : AW;
    endfunction

    function automatic logic [15:0] exp_word(input int a, input logic wide);
        if (wide) return {model[(2 * a) % DEPTH], model[(2 * a + 1) % DEPTH]};
        return {8'h00, model[a % DEPTH]};
    endfunction

    task automatic send_hdr(input logic [1:0] op, input int a, input logic wide);
        pin_bit(1'b1);
        pin_bit(op[1]);
        pin_bit(op[0]);
        for (int i = aw_of(wide) - 1; i >= 0; i--) pin_bit(a[i]);
    endtask

    // Model of the effect of one programming frame.
    task automatic model_prog(input logic [1:0] op, input int a, input logic [15:0] d, input logic wide);
        logic [1:0] sub;
        sub = wide ? 2'(a >> (AW - 3)) : 2'(a >> (AW - 2));
        if (op == 2'b00 && sub == 2'b11) unlocked = 1'b1;
        else if (op == 2'b00 && sub == 2'b00) unlocked = 1'b0;
        else if (unlocked) begin
            if (op == 2'b01 || op == 2'b11) begin
                logic [15:0] v;
                v = (op == 2'b11) ? 16'hFFFF : d;
                if (wide) begin
                    model[2 * a] = v[15:8];
                    model[2 * a + 1] = v[7:0];
                end else model[a] = v[7:0];
            end else if (sub == 2'b10) begin
                for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
            end else if (sub == 2'b01) begin
                for (int i = 0; i < DEPTH; i++)
                    model[i] = (wide && (i % 2 == 0)) ? d[15:8] : d[7:0];
            end
        end
    endtask

    // One programming frame; select is left low at the end.
    task automatic prog(input logic [1:0] op, input int a, input logic [15:0] d, input logic wide);
        logic [1:0] sub;
        logic has_data;
        sub = wide ? 2'(a >> (AW - 3)) : 2'(a >> (AW - 2));
        has_data = (op == 2'b01) || (op == 2'b00 && sub == 2'b01);
        w16 = wide;
        sel_on();
        send_hdr(op, a, wide);
        if (has_data && unlocked)
            for (int i = (wide ? 15 : 7); i >= 0; i--) pin_bit(d[i]);
        sel_off();
        model_prog(op, a, d, wide);
    endtask

    task automatic ext_cmd(input logic [1:0] sub, input logic [15:0] d);
        prog(2'b00, int'(sub) << (AW - 2), d, 1'b0);
    endtask

    task automatic wait_ready();
        idle(PROG + 30);
    endtask

    // Sequential read of n words with the dummy bit checked once.
    task automatic read_chk(input string tag, input int a, input logic wide, input int n);
        logic [15:0] got;
        int span;
        span = wide ? DEPTH / 2 : DEPTH;
        w16 = wide;
        sel_on();
        send_hdr(2'b10, a, wide);
        chk({tag, " R2 dummy"}, {14'h0, smp_oe, smp_do}, 16'h0002);
        for (int w = 0; w < n; w++) begin
            got = '0;
            for (int i = (wide ? 15 : 7); i >= 0; i--) begin
                pin_bit(1'b0);
                got[i] = smp_do;
            end
            chk(tag, got, exp_word((a + w) % span, wide));
        end
        sel_off();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int ra;
        logic rw;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        void'($urandom(32'd5309));
        idle(4);
        rst_n = 1'b1;
        idle(4);

        // R12: reset state
        chk("R12 reset oe", {15'h0, sout_en}, 16'h0000);

        // R4: locked write is ignored; no status afterwards (R11)
        prog(2'b01, 3, 16'h005A, 1'b0);
        sel_on();
        chk("R4 no busy when locked", {15'h0, sout_en}, 16'h0000);
        sel_off();
        read_chk("R4 locked write", 3, 1'b0, 1);

        // R5 unlock, R10 busy/ready status, R6 byte write
        ext_cmd(2'b11, 16'h0);
        prog(2'b01, 3, 16'h00A5, 1'b0);
        sel_on();
        chk("R10 busy", {14'h0, sout_en, sout}, 16'h0002);
        idle(PROG);
        chk("R10 ready", {14'h0, sout_en, sout}, 16'h0003);
        sel_off();
        chk("R12 oe off with sel", {15'h0, sout_en}, 16'h0000);

        // R11: select raised after the cycle ended
        prog(2'b01, 4, 16'h0011, 1'b0);
        wait_ready();
        sel_on();
        chk("R11 no status late", {15'h0, sout_en}, 16'h0000);
        sel_off();

        // R3: sequential read of two bytes
        read_chk("R3 seq bytes", 3, 1'b0, 2);

        // R6: word write and byte mapping
        prog(2'b01, 10, 16'h1234, 1'b1);
        wait_ready();
        read_chk("R6 word", 10, 1'b1, 1);
        read_chk("R6 byte map", 20, 1'b0, 2);

        // R7: erase a word
        prog(2'b11, 10, 16'h0, 1'b1);
        wait_ready();
        read_chk("R7 erase", 10, 1'b1, 1);

        // R3: wrap at the top of the byte space
        prog(2'b01, DEPTH - 1, 16'h0077, 1'b0);
        wait_ready();
        prog(2'b01, 0, 16'h0042, 1'b0);
        wait_ready();
        read_chk("R3 wrap", DEPTH - 1, 1'b0, 2);

        // R1: leading zeros before the start bit
        w16 = 1'b0;
        sel_on();
        pin_bit(1'b0);
        pin_bit(1'b0);
        send_hdr(2'b10, 3, 1'b0);
        chk("R1 dummy after zeros", {14'h0, smp_oe, smp_do}, 16'h0002);
        rv = '0;
        for (int i = 7; i >= 0; i--) begin
            pin_bit(1'b0);
            rv[i] = smp_do;
        end
        chk("R1 read after zeros", rv, exp_word(3, 1'b0));
        sel_off();

        // R13: a frame started while busy is not executed
        prog(2'b01, 40, 16'h00C3, 1'b0);
        w16 = 1'b0;
        sel_on();
        send_hdr(2'b01, 40, 1'b0);
        for (int i = 7; i >= 0; i--) pin_bit(1'b0);
        chk("R13 status kept", {15'h0, smp_oe}, 16'h0001);
        sel_off();
        wait_ready();
        read_chk("R13 ignored frame", 40, 1'b0, 1);

        // R14: frame dropped when select falls early
        w16 = 1'b0;
        sel_on();
        send_hdr(2'b01, 50, 1'b0);
        for (int i = 0; i < 4; i++) pin_bit(1'b0);
        sel_off();
        sel_on();
        chk("R14 no busy after drop", {15'h0, sout_en}, 16'h0000);
        sel_off();
        read_chk("R14 storage kept", 50, 1'b0, 1);

        // R9: write-all in word mode, R8: erase-all
        prog(2'b00, 1 << (AW - 3), 16'hBEEF, 1'b1);
        wait_ready();
        read_chk("R9 fill", 77, 1'b1, 2);
        read_chk("R9 fill bytes", 300, 1'b0, 1);
        ext_cmd(2'b10, 16'h0);
        wait_ready();
        read_chk("R8 wipe", 123, 1'b1, 1);
        read_chk("R8 wipe bytes", 0, 1'b0, 1);

        // R5: lock again; a write is then ignored
        ext_cmd(2'b00, 16'h0);
        prog(2'b01, 60, 16'h0001, 1'b0);
        wait_ready();
        read_chk("R5 locked again", 60, 1'b0, 1);
        ext_cmd(2'b11, 16'h0);

        // Random traffic (R6, R7, R2)
        for (int k = 0; k < 24; k++) begin
            rw = 1'($urandom_range(0, 1));
            ra = $urandom_range(0, rw ? DEPTH / 2 - 1 : DEPTH - 1);
            rv = 16'($urandom());
            if ($urandom_range(0, 3) == 0) prog(2'b11, ra, 16'h0, rw);
            else                           prog(2'b01, ra, rv, rw);
            wait_ready();
            read_chk("R6 random", ra, rw, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule